// File: doc/BRIEF.md
# Upstream Pull-Up Enable Delay Timer

This block controls the enable for the upstream D+ pull-up of a full-speed hub. After a system reset, and again after any change on the power-source select input, it keeps the enable low for a fixed number of core-clock cycles and then raises it. When the hub switches between bus power and self power, the host therefore sees a disconnect followed by a fresh attach. The block has no data stream; all of its pins are plain control levels.

The power-source select input is asynchronous. A two-stage synchronizer brings it into the core clock domain, and a change detector compares the synchronized level with its previous value. The hold time is the parameter `DELAY_CYCLES`. Its default of 144000 cycles gives 3 ms at a 48 MHz core clock. The pull-up, bus-reset signalling on the upstream port and every other hub function sit outside this block, so a bus reset has no path into the timer.

Top module: `pullup_delay_timer`

## Requirements
- R1: A rising clock edge that samples `rst_n` low leaves `pullup_en` low after that edge, and restarts the delay.
- R2: If `pwr_src_sel` changes level, rising or falling, between the samples taken at edges N-1 and N, then the edge N+2 restarts the delay and `pullup_en` is low after it.
- R3: With no further restart, `pullup_en` goes high after exactly the `DELAY_CYCLES`-th rising edge that follows the restarting edge, and it is low after every edge before that one.
- R4: Once high, `pullup_en` stays high until the next reset edge or input-change restart. The internal count saturates and does not wrap.
- R5: The level that `pwr_src_sel` has at the last reset edge becomes the baseline. Leaving reset causes no extra restart, whether that level is 0 or 1.
- R6: A change that arrives while the delay is running restarts the full `DELAY_CYCLES` period from the new restart edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low system reset, sampled on the rising clock edge |
| pwr_src_sel | input | 1 | Power-source select level (bus or self power), asynchronous |
| pullup_en | output | 1 | Upstream D+ pull-up enable, active high |

## Verification
The bench goes after the exact rise cycle. A counter that is off by one would raise the enable one edge early or one edge late. It also checks that a change arriving in the middle of the delay starts the full period again. A design that kept counting from the old value, or ignored changes while the enable was still low, would release the pull-up too soon. Reset is applied with the select input both high and low, to catch a synchronizer that is not loaded from the input and so reports a false change right after reset. Single-cycle pulses on the select input check that each of the two edges restarts the delay on its own, and long quiet stretches check that the saturated count never wraps and drops the enable.

// File: rtl/pullup_delay_pkg.sv
package pullup_delay_pkg;

  typedef enum logic {
    PU_HOLD = 1'b0,
    PU_ON   = 1'b1
  } pu_state_e;

  function automatic int cnt_width(input int max_val);
    int w;
    w = 1;
    while ((1 << w) <= max_val) w++;
    return w;
  endfunction

endpackage

// File: rtl/pwrsel_sync.sv
module pwrsel_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] chain_q;

  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[g] <= din;
          else        chain_q[g] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[g] <= din;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign dout = chain_q[LAST];
endmodule

// File: rtl/level_change_det.sv
module level_change_det (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_lvl,
  input  logic sync_lvl,
  output logic changed
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= raw_lvl;
    else        prev_q <= sync_lvl;
  end

  assign changed = sync_lvl ^ prev_q;
endmodule

// File: rtl/pullup_delay_counter.sv
module pullup_delay_counter
  import pullup_delay_pkg::*;
#(
  parameter int DELAY_CYCLES = 144000,
  parameter int CW           = 18
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic en_o
);
  localparam logic [CW-1:0] TERM = CW'(DELAY_CYCLES - 1);

  pu_state_e      st_q;
  logic [CW-1:0]  cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      st_q  <= PU_HOLD;
      cnt_q <= '0;
    end else if (st_q == PU_HOLD) begin
      if (cnt_q == TERM) st_q  <= PU_ON;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end

  assign en_o = (st_q == PU_ON);
endmodule

// File: rtl/pullup_delay_timer.sv
module pullup_delay_timer
  import pullup_delay_pkg::*;
#(
  parameter int DELAY_CYCLES = 144000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_src_sel,
  output logic pullup_en
);
  localparam int CW = cnt_width(DELAY_CYCLES);

  logic sel_sync;
  logic src_chg;

  pwrsel_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (pwr_src_sel),
    .dout  (sel_sync)
  );

  level_change_det u_det (
    .clk      (clk),
    .rst_n    (rst_n),
    .raw_lvl  (pwr_src_sel),
    .sync_lvl (sel_sync),
    .changed  (src_chg)
  );

  pullup_delay_counter #(.DELAY_CYCLES(DELAY_CYCLES), .CW(CW)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (src_chg),
    .en_o    (pullup_en)
  );
endmodule

// File: rtl/pullup_delay_chk.sv
module pullup_delay_chk #(
  parameter int DELAY_CYCLES = 144000
) (
  input logic clk,
  input logic rst_n,
  input logic chg,
  input logic pullup_en
);
  localparam int WW = $clog2(DELAY_CYCLES + 1) + 1;
  localparam logic [WW-1:0] LIM = WW'(DELAY_CYCLES);

  logic [WW-1:0] win_q;

  always_ff @(posedge clk) begin
    if (!rst_n || chg)   win_q <= '0;
    else if (win_q != LIM) win_q <= win_q + 1'b1;
  end

  AST_RESET_FORCES_LOW: assert property (@(posedge clk) !rst_n |=> !pullup_en); // R1
  AST_CHANGE_FORCES_LOW: assert property (@(posedge clk) disable iff (!rst_n) chg |=> !pullup_en); // R2
  AST_LEVEL_MATCHES_WINDOW: assert property (@(posedge clk) disable iff (!rst_n) pullup_en == (win_q == LIM)); // R3
  AST_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n) (pullup_en && !chg) |=> pullup_en); // R4
endmodule

bind pullup_delay_timer pullup_delay_chk #(.DELAY_CYCLES(DELAY_CYCLES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .chg       (src_chg),
  .pullup_en (pullup_en)
);

// File: tb/test_pullup_delay_timer.sv
module test_pullup_delay_timer;
  localparam int DLY = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 1'b1;
  logic pullup_en;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  // reference model state
  logic h1, h2, h3;
  int   since = 0;
  bit   exp_en = 1'b0;
  bit   exp_prev = 1'b0;
  bit   in_rst = 1'b1;
  bit   by_input = 1'b0;
  bit   mid_restart = 1'b0;

  always #2 clk = ~clk;

  pullup_delay_timer #(.DELAY_CYCLES(DLY)) i_pullup_delay_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwr_src_sel (sel),
    .pullup_en   (pullup_en)
  );

  function automatic bit next_exp(input int s);
    return s >= DLY;
  endfunction

  always @(posedge clk) begin
    exp_prev = exp_en;
    if (!rst_n) begin
      h1 = sel; h2 = sel; h3 = sel;
      since = 0; in_rst = 1'b1; by_input = 1'b0; mid_restart = 1'b0;
    end else begin
      in_rst = 1'b0;
      if (h2 != h3) begin
        mid_restart = (!exp_en && since > 0);
        since = 0; by_input = 1'b1;
      end else if (since < DLY) begin
        since++;
      end
      h3 = h2; h2 = h1; h1 = sel;
    end
    exp_en = next_exp(since);
  end

  task automatic check_now();
    string tag;
    if (in_rst)                    tag = "R1";
    else if (exp_en && !exp_prev)  tag = "R3";
    else if (exp_en)               tag = "R4";
    else if (mid_restart)          tag = "R6";
    else if (by_input)             tag = "R2";
    else                           tag = "R5";
    n_chk++;
    if (pullup_en !== exp_en) begin
      n_fail++;
      $display("FAIL %s: pullup_en=%b expected=%b at %0t", tag, pullup_en, exp_en, $time);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check_now();
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_2036));
    // R1 and R5: reset with select high, then leave it untouched
    step(5);
    rst_n = 1'b1;
    step(DLY + 10);
    // R2: falling change, full period
    sel = 1'b0;
    step(DLY + 8);
    // R6: change again midway through the delay
    sel = 1'b1;
    step(DLY / 2);
    sel = 1'b0;
    step(DLY + 8);
    // R1 while high, with select low during reset (R5 baseline low)
    rst_n = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(DLY + 5);
    // R2: single-cycle pulse gives two restarts
    sel = 1'b1;
    step(1);
    sel = 1'b0;
    step(DLY + 6);
    // R1: change on the last reset cycle is absorbed into the baseline (R5)
    rst_n = 1'b0;
    step(2);
    sel = 1'b1;
    step(1);
    rst_n = 1'b1;
    step(DLY + 5);
    // constrained random mix
    for (int k = 0; k < 4000; k++) begin
      if ($urandom_range(0, 39) == 0) sel = ~sel;
      rst_n = ($urandom_range(0, 599) != 0);
      step(1);
    end
    rst_n = 1'b1;
    // R4: long quiet stretch, saturated count must hold
    step(DLY * 6);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule